// File: doc/BRIEF.md
# Interleaved Grid-Cluster Read Memory

This block holds a two-dimensional grid of data words spread over a 4x4 array of independently addressed dual-port RAM banks. Each read request gives a base coordinate (X, Y). The block then returns the whole 4x4 window of words whose top-left corner is at that base, all in one pipelined access. A smaller footprint, such as the 2x2 neighbourhood that bilinear interpolation needs, is a subset of that window. The base may take any alignment. The banks never conflict, because the cell at (x, y) always lives in bank (x mod 4, y mod 4).

The path has three stages. Per-bank address generation adds a wraparound carry to the quotient of the base coordinate. The banked RAM array follows. Last comes a de-interleaving network, built from two cascaded layers of 4:1 multiplexers and driven by the delayed low bits of the base. It rotates the bank outputs back into fixed window order. A separate port writes one word per cycle at any cell, concurrently with reads.

Top module: `gcm_cluster_mem`

## Requirements
- R1: While `rst` is high at a rising clock edge, `rd_valid` is low after that edge.
- R2: `rd_valid` is high exactly two clock edges after an edge at which `rd_req` was sampled high, and low two edges after an edge at which `rd_req` was sampled low.
- R3: A word written at cell (x, y) is returned by a later read whose window covers that cell.
- R4: The window returns correct data for any base alignment, including bases whose low two bits are nonzero in one or both axes, where some banks must use the next row or column of bank addresses.
- R5: Within `rd_cluster`, window position (dx, dy) occupies bits [(dy*4+dx)*DW +: DW] and carries grid cell (X+dx, Y+dy).
- R6: A write changes only the addressed cell. Every other cell of a window read afterwards keeps its previous value.
- R7: When a read and a write in the same cycle touch the same cell, the read returns the value held before the write, and a later read returns the new value.
- R8: A write in the same cycle as a read to other cells does not disturb that read's data.
- R9: A new read may be issued on every clock cycle, and the results come back in issue order, one per cycle.
- R10: A write enables exactly one bank, the bank (wr_x mod 4, wr_y mod 4). When `wr_en` is low, no bank is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Start a window read this cycle |
| rd_x | input | log2(GX) | Base column of the window |
| rd_y | input | log2(GY) | Base row of the window |
| wr_en | input | 1 | Write one word this cycle |
| wr_x | input | log2(GX) | Column of the written cell |
| wr_y | input | log2(GY) | Row of the written cell |
| wr_data | input | DW | Word to write |
| rd_valid | output | 1 | Window data valid |
| rd_cluster | output | 16*DW | The 4x4 window, packed as in R5 |

## Verification
The address and wraparound checks assume that the caller keeps every window inside the grid, meaning X <= GX-4 and Y <= GY-4. The latency checks assume that `rd_req` is held low during reset. The stimulus draws base coordinates only from 0..GX-4 and 0..GY-4, while write coordinates span the full grid. It holds every request input low for as long as reset is applied. Directed cases add unaligned bases, the last legal corner, and same-cell read/write collisions on top of the randomly mixed traffic.

// File: rtl/gcm_pkg.sv
package gcm_pkg;

    // Banks per axis; the window is NB x NB cells.
    localparam int NB  = 4;
    localparam int LNB = 2;

    // Per-request steering information that travels with the RAM read.
    typedef struct packed {
        logic           valid;
        logic [LNB-1:0] xlo;
        logic [LNB-1:0] ylo;
    } lane_tag_t;

    // Quotient of a coordinate by the bank count, plus a wrap carry when
    // the bank index lies below the base's low bits.
    function automatic int wrap_quot(input int coord, input int bank);
        int q;
        q = coord / NB;
        if (bank < (coord % NB))
            q = q + 1;
        return q;
    endfunction

endpackage

// File: rtl/gcm_addr_gen.sv
module gcm_addr_gen
    import gcm_pkg::*;
#(
    parameter int GX = 16,
    parameter int GY = 16,
    localparam int XW    = $clog2(GX),
    localparam int YW    = $clog2(GY),
    localparam int QX    = GX / NB,
    localparam int QY    = GY / NB,
    localparam int DEPTH = QX * QY,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    output logic [AW-1:0] addr [NB][NB]
);

    int col_q [NB];
    int row_q [NB];

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            col_q[b] = wrap_quot(int'(x), b);
            row_q[b] = wrap_quot(int'(y), b);
        end
        for (int by = 0; by < NB; by++)
            for (int bx = 0; bx < NB; bx++)
                addr[by][bx] = AW'(row_q[by] * QX + col_q[bx]);
    end

    // R4: bank quotients step down by at most one across the bank index,
    // and never rise, for any base alignment.
    for (genvar b = 1; b < NB; b++) begin : g_wrap_chk
        p_wrap_step_r4: assert property (@(posedge clk) disable iff (rst)
            (col_q[b] <= col_q[b-1]) && (col_q[b-1] - col_q[b] <= 1) &&
            (row_q[b] <= row_q[b-1]) && (row_q[b-1] - row_q[b] <= 1));
    end

endmodule

// File: rtl/gcm_bank.sv
module gcm_bank #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Read-before-write: a same-address read sees the old word.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/gcm_deinterleave.sv
module gcm_deinterleave
    import gcm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  lane_tag_t     tag,
    input  logic [DW-1:0] bank_q   [NB][NB],
    output logic          out_valid,
    output logic [DW-1:0] out_word [NB][NB]
);

    logic [DW-1:0] row_pick [NB][NB];
    logic [DW-1:0] pos_c    [NB][NB];

    // Layer 1 picks the bank row for each window row, layer 2 picks the
    // bank column for each window column: two 4:1 stages per output.
    always_comb begin
        logic [LNB-1:0] ry;
        logic [LNB-1:0] rx;
        for (int dy = 0; dy < NB; dy++) begin
            ry = tag.ylo + LNB'(dy);
            for (int bx = 0; bx < NB; bx++)
                row_pick[dy][bx] = bank_q[ry][bx];
        end
        for (int dy = 0; dy < NB; dy++)
            for (int dx = 0; dx < NB; dx++) begin
                rx = tag.xlo + LNB'(dx);
                pos_c[dy][dx] = row_pick[dy][rx];
            end
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= tag.valid;
        out_word <= pos_c;
    end

endmodule

// File: rtl/gcm_cluster_mem.sv
module gcm_cluster_mem
    import gcm_pkg::*;
#(
    parameter int DW = 16,
    parameter int GX = 16,
    parameter int GY = 16,
    localparam int XW = $clog2(GX),
    localparam int YW = $clog2(GY),
    localparam int CW = NB * NB * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic [XW-1:0] rd_x,
    input  logic [YW-1:0] rd_y,
    input  logic          wr_en,
    input  logic [XW-1:0] wr_x,
    input  logic [YW-1:0] wr_y,
    input  logic [DW-1:0] wr_data,
    output logic          rd_valid,
    output logic [CW-1:0] rd_cluster
);

    localparam int QX    = GX / NB;
    localparam int QY    = GY / NB;
    localparam int DEPTH = QX * QY;
    localparam int AW    = $clog2(DEPTH);

    logic [AW-1:0]    rd_addr  [NB][NB];
    logic [DW-1:0]    bank_q   [NB][NB];
    logic [DW-1:0]    out_word [NB][NB];
    logic [NB*NB-1:0] we_vec;
    logic [AW-1:0]    wr_addr;
    lane_tag_t        tag_s1;

    gcm_addr_gen #(.GX(GX), .GY(GY)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .x    (rd_x),
        .y    (rd_y),
        .addr (rd_addr)
    );

    // Write decode: low bits select the bank, high bits the bank word.
    always_comb begin
        we_vec  = '0;
        wr_addr = AW'(int'(wr_y >> LNB) * QX + int'(wr_x >> LNB));
        if (wr_en)
            we_vec[{wr_y[LNB-1:0], wr_x[LNB-1:0]}] = 1'b1;
    end

    for (genvar by = 0; by < NB; by++) begin : g_row
        for (genvar bx = 0; bx < NB; bx++) begin : g_col
            gcm_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
                .clk   (clk),
                .we    (we_vec[by*NB+bx]),
                .waddr (wr_addr),
                .wdata (wr_data),
                .raddr (rd_addr[by][bx]),
                .rdata (bank_q[by][bx])
            );
        end
    end

    // Steering bits delayed to line up with the RAM output.
    always_ff @(posedge clk) begin
        if (rst)
            tag_s1 <= '0;
        else
            tag_s1 <= '{valid: rd_req, xlo: rd_x[LNB-1:0], ylo: rd_y[LNB-1:0]};
    end

    gcm_deinterleave #(.DW(DW)) u_deint (
        .clk       (clk),
        .rst       (rst),
        .tag       (tag_s1),
        .bank_q    (bank_q),
        .out_valid (rd_valid),
        .out_word  (out_word)
    );

    always_comb begin
        for (int dy = 0; dy < NB; dy++)
            for (int dx = 0; dx < NB; dx++)
                rd_cluster[(dy*NB+dx)*DW +: DW] = out_word[dy][dx];
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !rd_valid);

    p_latency_hit_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> ##2 rd_valid);

    p_latency_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_req |-> ##2 !rd_valid);

    p_one_bank_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_vec) && (wr_en == ($countones(we_vec) == 1)));

endmodule

// File: tb/tb_gcm_cluster_mem.sv
`timescale 1ns/1ps
module tb_gcm_cluster_mem;

    localparam int DW = 16;
    localparam int GX = 16;
    localparam int GY = 16;
    localparam int XW = $clog2(GX);
    localparam int YW = $clog2(GY);
    localparam int CW = 16 * DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_req = 1'b0;
    logic [XW-1:0] rd_x = '0;
    logic [YW-1:0] rd_y = '0;
    logic          wr_en = 1'b0;
    logic [XW-1:0] wr_x = '0;
    logic [YW-1:0] wr_y = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_valid;
    logic [CW-1:0] rd_cluster;

    gcm_cluster_mem #(.DW(DW), .GX(GX), .GY(GY)) dut (.*);

    always #2.5 clk = ~clk;

    int n_vec  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic [DW-1:0] model [GY][GX];
    logic [CW-1:0] exp_q [$];
    int            cyc_q [$];
    string         tag_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    // R5 layout: position (dx,dy) at bits [(dy*4+dx)*DW +: DW].
    function automatic logic [CW-1:0] exp_window(input int x, input int y);
        logic [CW-1:0] r;
        for (int dy = 0; dy < 4; dy++)
            for (int dx = 0; dx < 4; dx++)
                r[(dy*4+dx)*DW +: DW] = model[y+dy][x+dx];
        return r;
    endfunction

    // Drive one cycle of stimulus; expected read data is taken before the
    // same-cycle write lands in the model (R7).
    task automatic do_op(input bit rd, input int x, input int y,
                         input bit wr, input int wx, input int wy,
                         input logic [DW-1:0] wd, input string tag);
        @(negedge clk);
        rd_req  = rd;
        rd_x    = XW'(x);
        rd_y    = YW'(y);
        wr_en   = wr;
        wr_x    = XW'(wx);
        wr_y    = YW'(wy);
        wr_data = wd;
        if (rd) begin
            exp_q.push_back(exp_window(x, y));
            cyc_q.push_back(cyc);
            tag_q.push_back(tag);
        end
        if (wr)
            model[wy][wx] = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            do_op(0, 0, 0, 0, 0, 0, '0, "");
    endtask

    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected rd_valid: actual=1 expected=0");
            end else begin
                logic [CW-1:0] e;
                int            c;
                string         t;
                e = exp_q.pop_front();
                c = cyc_q.pop_front();
                t = tag_q.pop_front();
                if (cyc != c + 2) begin
                    n_fail++;
                    $display("FAIL R2 latency: actual=%0d expected=%0d", cyc - c, 2);
                end else if (rd_cluster !== e) begin
                    n_fail++;
                    $display("FAIL %s window: actual=%h expected=%h", t, rd_cluster, e);
                end
            end
        end
    end

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL R9 watchdog expired: actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (rd_valid !== 1'b0) begin   // R1
            n_fail++;
            $display("FAIL R1 reset: actual=%b expected=0", rd_valid);
        end
        rst = 1'b0;

        // Fill the whole grid (R3).
        for (int y = 0; y < GY; y++)
            for (int x = 0; x < GX; x++)
                do_op(0, 0, 0, 1, x, y, DW'($urandom), "");
        idle(2);

        // Directed reads.
        do_op(1, 0, 0, 0, 0, 0, '0, "R3");
        do_op(1, 2, 1, 0, 0, 0, '0, "R5");
        do_op(1, 3, 7, 0, 0, 0, '0, "R4");
        do_op(1, 5, 6, 0, 0, 0, '0, "R4");
        do_op(1, 11, 9, 0, 0, 0, '0, "R4");
        do_op(1, GX-4, GY-4, 0, 0, 0, '0, "R4");
        idle(3);   // R2: no valid may appear here

        // R6 and R10: single write, neighbours unchanged.
        do_op(0, 0, 0, 1, 9, 9, 16'hBEEF, "");
        do_op(1, 8, 8, 0, 0, 0, '0, "R6");
        // R7: same-cell collision, then read back.
        do_op(1, 4, 4, 1, 5, 6, 16'h1234, "R7");
        do_op(1, 4, 4, 0, 0, 0, '0, "R7");
        idle(3);

        // Random mixed traffic, reads back to back (R8, R9).
        for (int i = 0; i < 600; i++) begin
            bit rd;
            bit wr;
            rd = ($urandom % 4) != 0;
            wr = ($urandom % 2) != 0;
            do_op(rd, int'($urandom % (GX-3)), int'($urandom % (GY-3)),
                  wr, int'($urandom % GX), int'($urandom % GY),
                  DW'($urandom), wr ? "R8" : "R9");
        end
        idle(4);

        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 lost results: actual=%0d expected=0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule